// File: doc/BRIEF.md
# Float to unsigned integer converter

This block turns one IEEE-754 binary floating-point value into an unsigned integer. It rounds to the nearest integer, and a value exactly halfway between two integers goes to the one of larger magnitude. The source can be half, single or double precision, picked by a 2-bit format code. The destination is 32 or 64 bits wide, picked by a width bit. The operand comes in on a 64-bit bus, and narrower formats sit in its low bits.

The result is saturating. A value too large for the chosen width gives all ones. NaN gives zero. A negative value that rounds to a nonzero magnitude gives zero. Each conversion reports an invalid, an inexact or an undefined-format indication.

For each exception class, a per-class trap enable decides what happens:
- If the trap is enabled, the exception raises a one-cycle trap request.
- If it is disabled, the exception sets a sticky status bit that stays set until reset.

A conversion starts on a cycle with `in_valid` high. Its result appears on the registered outputs one clock later.

Top module: `fp2u_cvt`

## Requirements
- R1: Format code 11 selects half precision in operand bits [15:0]. Code 00 selects single precision in bits [31:0]. Code 01 selects double precision in bits [63:0]. Operand bits above the selected format have no effect on any output.
- R2: Format code 10 sets `exc_undef`. The result is 0 and neither `exc_invalid` nor `exc_inexact` is set.
- R3: `dst_wide` = 0 limits the result to 32 bits with bits [63:32] driven to 0. `dst_wide` = 1 gives a 64-bit result.
- R4: Finite values round to the nearest integer, with exact halfway cases going away from zero (2.5 gives 3, 0.5 gives 1). A representable result that needed rounding sets `exc_inexact`.
- R5: A NaN of any format gives result 0 with `exc_invalid` set.
- R6: +infinity, or a value whose rounded magnitude exceeds the selected width's maximum, gives all ones of that width (0xFFFFFFFF or 0xFFFFFFFFFFFFFFFF) with `exc_invalid` set.
- R7: For negative inputs, the outcome depends on the magnitude:
  - Below 0.5: result 0 with only `exc_inexact` set.
  - 0.5 or more, including -infinity: result 0 with only `exc_invalid` set.
  - Positive or negative zero: result 0 with no flags.
- R8: A nonzero subnormal input gives result 0 with `exc_inexact` set.
- R9: `exc_invalid` and `exc_inexact` are never both set for one conversion.
- R10: A conversion presented with `in_valid` appears on the outputs with `out_valid` high one clock later. `out_valid` is low in the following cycle unless another conversion was presented.
- R11: Invalid and inexact are handled independently:
  - If a class's trap enable is set, its exception pulses `trap_req` with that conversion's result and leaves the class's sticky bit unchanged.
  - If the enable is clear, the sticky bit is set.
  - Sticky bits stay set until reset.
- R12: While reset is high, all outputs, including the sticky bits and `trap_req`, are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start a conversion this cycle |
| src_fmt | input | 2 | Source format code (00 single, 01 double, 11 half, 10 illegal) |
| dst_wide | input | 1 | 0: 32-bit result, 1: 64-bit result |
| operand | input | 64 | Floating-point operand, low-aligned |
| trap_iv_en | input | 1 | Route invalid exceptions to the trap request |
| trap_ix_en | input | 1 | Route inexact exceptions to the trap request |
| out_valid | output | 1 | Result and flags are for a new conversion |
| result | output | 64 | Unsigned integer result |
| exc_invalid | output | 1 | Invalid operation for this conversion |
| exc_inexact | output | 1 | Rounding changed the value for this conversion |
| exc_undef | output | 1 | Illegal source format code |
| sticky_invalid | output | 1 | Accumulated untrapped invalid exceptions |
| sticky_inexact | output | 1 | Accumulated untrapped inexact exceptions |
| trap_req | output | 1 | Trapped exception raised by this conversion |

## Verification
A wrong shift count or a bad round-bit position shows up on the very next `out_valid` cycle:
- Halfway values come out as the wrong integer.
- Values just below a power of two lose their low bits.

A broken overflow comparison shows in the same cycle, because values at exactly 2^32 or 2^64 fail to saturate or saturate when they should not. Faults in the trap and sticky path appear one clock after an excepting conversion and then persist on the sticky outputs until reset. Each result and flag check is therefore taken in the cycle straight after the conversion is presented.

// File: rtl/fp2u_pkg.sv
package fp2u_pkg;
  localparam int OPND_W = 64;
  localparam int RES_W  = 64;
  localparam int NAR_W  = 32;
  localparam int SIG_W  = 53;
  localparam int XP_W   = 13;
  localparam int N_FMT  = 3;

  localparam logic [1:0] FMT_SP = 2'b00;
  localparam logic [1:0] FMT_DP = 2'b01;
  localparam logic [1:0] FMT_HP = 2'b11;

  typedef enum logic [1:0] {
    C_ZERO = 2'd0,
    C_FIN  = 2'd1,
    C_INF  = 2'd2,
    C_NAN  = 2'd3
  } cls_e;

  function automatic int fmt_exp_w(int idx);
    return (idx == 0) ? 5 : (idx == 1) ? 8 : 11;
  endfunction

  function automatic int fmt_man_w(int idx);
    return (idx == 0) ? 10 : (idx == 1) ? 23 : 52;
  endfunction
endpackage

// File: rtl/fp2u_field.sv
module fp2u_field
  import fp2u_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int SG_W  = 53,
  parameter int XW    = 13
) (
  input  logic [EXP_W+MAN_W:0]  bits_i,
  output logic                  sign_o,
  output cls_e                  cls_o,
  output logic signed [XW-1:0]  exp_o,
  output logic [SG_W-1:0]       sig_o
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int PAD  = SG_W - 1 - MAN_W;

  logic [EXP_W-1:0] e_f;
  logic [MAN_W-1:0] m_f;

  assign e_f    = bits_i[EXP_W+MAN_W-1:MAN_W];
  assign m_f    = bits_i[MAN_W-1:0];
  assign sign_o = bits_i[EXP_W+MAN_W];

  always_comb begin
    if (&e_f) begin
      cls_o = (m_f != '0) ? C_NAN : C_INF;
      exp_o = XW'(BIAS + 1);
      sig_o = '0;
    end else if (e_f == '0) begin
      cls_o = (m_f != '0) ? C_FIN : C_ZERO;
      exp_o = XW'(1 - BIAS);
      sig_o = {1'b0, m_f, {PAD{1'b0}}};
    end else begin
      cls_o = C_FIN;
      exp_o = $signed(XW'(e_f)) - $signed(XW'(BIAS));
      sig_o = {1'b1, m_f, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fp2u_unpack.sv
module fp2u_unpack
  import fp2u_pkg::*;
(
  input  logic [1:0]              fmt_i,
  input  logic [OPND_W-1:0]       opnd_i,
  output logic                    undef_o,
  output logic                    sign_o,
  output cls_e                    cls_o,
  output logic signed [XP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]        sig_o
);
  logic                   s_a [N_FMT];
  cls_e                   c_a [N_FMT];
  logic signed [XP_W-1:0] x_a [N_FMT];
  logic [SIG_W-1:0]       g_a [N_FMT];

  for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
    localparam int EW = fmt_exp_w(g);
    localparam int MW = fmt_man_w(g);
    fp2u_field #(
      .EXP_W(EW), .MAN_W(MW), .SG_W(SIG_W), .XW(XP_W)
    ) i_field (
      .bits_i (opnd_i[EW+MW:0]),
      .sign_o (s_a[g]),
      .cls_o  (c_a[g]),
      .exp_o  (x_a[g]),
      .sig_o  (g_a[g])
    );
  end

  always_comb begin
    int sel;
    undef_o = 1'b0;
    case (fmt_i)
      FMT_HP:  sel = 0;
      FMT_SP:  sel = 1;
      FMT_DP:  sel = 2;
      default: begin sel = 0; undef_o = 1'b1; end
    endcase
    sign_o = s_a[sel];
    cls_o  = c_a[sel];
    exp_o  = x_a[sel];
    sig_o  = g_a[sel];
  end
endmodule

// File: rtl/fp2u_round.sv
module fp2u_round #(
  parameter int RW = 64,
  parameter int SW = 53,
  parameter int XW = 13
) (
  input  logic signed [XW-1:0] exp_i,
  input  logic [SW-1:0]        sig_i,
  output logic [RW:0]          mag_o,
  output logic                 huge_o,
  output logic                 inexact_o
);
  localparam int VW   = 2 * RW;
  localparam int SH_W = $clog2(VW);
  localparam int OFS  = RW - (SW - 1);

  logic [VW-1:0]   vv;
  logic [SH_W-1:0] sh;
  logic            tiny;
  logic            rnd_bit;
  logic            stk_bit;

  assign tiny   = (exp_i < -1);
  assign huge_o = (exp_i >= RW);
  assign sh     = SH_W'(exp_i + XW'(OFS));
  assign vv     = {{(VW-SW){1'b0}}, sig_i} << sh;
  assign rnd_bit = vv[RW-1];
  assign stk_bit = |vv[RW-2:0];

  always_comb begin
    if (tiny) begin
      mag_o     = '0;
      inexact_o = |sig_i;
    end else if (huge_o) begin
      mag_o     = '0;
      inexact_o = 1'b0;
    end else begin
      mag_o     = {1'b0, vv[VW-1:RW]} + (RW+1)'(rnd_bit);
      inexact_o = rnd_bit | stk_bit;
    end
  end
endmodule

// File: rtl/fp2u_resolve.sv
module fp2u_resolve
  import fp2u_pkg::*;
(
  input  logic             undef_i,
  input  logic             sign_i,
  input  cls_e             cls_i,
  input  logic             wide_i,
  input  logic [RES_W:0]   mag_i,
  input  logic             huge_i,
  input  logic             inexact_i,
  output logic [RES_W-1:0] res_o,
  output logic             iv_o,
  output logic             ix_o
);
  logic [RES_W-1:0] max_v;
  logic             ovf;

  assign max_v = wide_i ? {RES_W{1'b1}} : {{(RES_W-NAR_W){1'b0}}, {NAR_W{1'b1}}};
  assign ovf   = huge_i | (wide_i ? mag_i[RES_W] : (|mag_i[RES_W:NAR_W]));

  always_comb begin
    res_o = '0;
    iv_o  = 1'b0;
    ix_o  = 1'b0;
    if (!undef_i) begin
      case (cls_i)
        C_NAN: iv_o = 1'b1;
        C_INF: begin
          iv_o = 1'b1;
          if (!sign_i) res_o = max_v;
        end
        C_FIN: begin
          if (sign_i) begin
            if (huge_i || mag_i != '0) iv_o = 1'b1;
            else                       ix_o = inexact_i;
          end else if (ovf) begin
            res_o = max_v;
            iv_o  = 1'b1;
          end else begin
            res_o = mag_i[RES_W-1:0];
            ix_o  = inexact_i;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fp2u_cvt.sv
module fp2u_cvt
  import fp2u_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        src_fmt,
  input  logic              dst_wide,
  input  logic [OPND_W-1:0] operand,
  input  logic              trap_iv_en,
  input  logic              trap_ix_en,
  output logic              out_valid,
  output logic [RES_W-1:0]  result,
  output logic              exc_invalid,
  output logic              exc_inexact,
  output logic              exc_undef,
  output logic              sticky_invalid,
  output logic              sticky_inexact,
  output logic              trap_req
);
  logic                   u_undef;
  logic                   u_sign;
  cls_e                   u_cls;
  logic signed [XP_W-1:0] u_exp;
  logic [SIG_W-1:0]       u_sig;
  logic [RES_W:0]         r_mag;
  logic                   r_huge;
  logic                   r_inx;
  logic [RES_W-1:0]       f_res;
  logic                   f_iv;
  logic                   f_ix;

  fp2u_unpack i_unpack (
    .fmt_i   (src_fmt),
    .opnd_i  (operand),
    .undef_o (u_undef),
    .sign_o  (u_sign),
    .cls_o   (u_cls),
    .exp_o   (u_exp),
    .sig_o   (u_sig)
  );

  fp2u_round #(.RW(RES_W), .SW(SIG_W), .XW(XP_W)) i_round (
    .exp_i     (u_exp),
    .sig_i     (u_sig),
    .mag_o     (r_mag),
    .huge_o    (r_huge),
    .inexact_o (r_inx)
  );

  fp2u_resolve i_resolve (
    .undef_i   (u_undef),
    .sign_i    (u_sign),
    .cls_i     (u_cls),
    .wide_i    (dst_wide),
    .mag_i     (r_mag),
    .huge_i    (r_huge),
    .inexact_i (r_inx),
    .res_o     (f_res),
    .iv_o      (f_iv),
    .ix_o      (f_ix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      result         <= '0;
      exc_invalid    <= 1'b0;
      exc_inexact    <= 1'b0;
      exc_undef      <= 1'b0;
      sticky_invalid <= 1'b0;
      sticky_inexact <= 1'b0;
      trap_req       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      trap_req  <= in_valid & ((f_iv & trap_iv_en) | (f_ix & trap_ix_en));
      if (in_valid) begin
        result      <= f_res;
        exc_invalid <= f_iv;
        exc_inexact <= f_ix;
        exc_undef   <= u_undef;
        if (f_iv && !trap_iv_en) sticky_invalid <= 1'b1;
        if (f_ix && !trap_ix_en) sticky_inexact <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/fp2u_chk.sv
module fp2u_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        dst_wide,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        exc_invalid,
  input logic        exc_inexact,
  input logic        exc_undef,
  input logic        sticky_invalid,
  input logic        sticky_inexact,
  input logic        trap_req
);
  // R2
  a_r2_undef_clean: assert property (@(posedge clk) disable iff (rst)
    (out_valid && exc_undef) |-> (result == '0 && !exc_invalid && !exc_inexact));

  // R9
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(exc_invalid && exc_inexact));

  // R3
  a_r3_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dst_wide) |=> (result[63:32] == 32'h0));

  // R10
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r10_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R11
  a_r11_sticky_iv_hold: assert property (@(posedge clk) disable iff (rst)
    sticky_invalid |=> sticky_invalid);

  a_r11_sticky_ix_hold: assert property (@(posedge clk) disable iff (rst)
    sticky_inexact |=> sticky_inexact);

  a_r11_trap_cause: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (out_valid && (exc_invalid || exc_inexact)));

  // R6
  a_r6_saturate_shape: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_wide) |=> (!(exc_invalid && result != '0) || result == {64{1'b1}}));
endmodule

bind fp2u_cvt fp2u_chk i_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .dst_wide       (dst_wide),
  .out_valid      (out_valid),
  .result         (result),
  .exc_invalid    (exc_invalid),
  .exc_inexact    (exc_inexact),
  .exc_undef      (exc_undef),
  .sticky_invalid (sticky_invalid),
  .sticky_inexact (sticky_inexact),
  .trap_req       (trap_req)
);

// File: tb/test_fp2u_cvt.sv
`timescale 1ns/1ps
module test_fp2u_cvt;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  src_fmt = 2'b00;
  logic        dst_wide = 1'b0;
  logic [63:0] operand = '0;
  logic        trap_iv_en = 1'b0;
  logic        trap_ix_en = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        exc_invalid, exc_inexact, exc_undef;
  logic        sticky_invalid, sticky_inexact, trap_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fp2u_cvt i_fp2u_cvt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_fmt(src_fmt),
    .dst_wide(dst_wide), .operand(operand), .trap_iv_en(trap_iv_en),
    .trap_ix_en(trap_ix_en), .out_valid(out_valid), .result(result),
    .exc_invalid(exc_invalid), .exc_inexact(exc_inexact), .exc_undef(exc_undef),
    .sticky_invalid(sticky_invalid), .sticky_inexact(sticky_inexact),
    .trap_req(trap_req)
  );

  typedef struct packed {
    logic [1:0]  f;
    logic        w;
    logic [63:0] op;
    logic [63:0] res;
    logic [2:0]  fl;   // {invalid, inexact, undef}
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VT [NV] = '{
    '{2'b00, 1'b0, 64'h3F800000,         64'h1,                 3'b000}, // R4 1.0
    '{2'b00, 1'b0, 64'h40200000,         64'h3,                 3'b010}, // R4 2.5 tie away
    '{2'b00, 1'b0, 64'h3FC00000,         64'h2,                 3'b010}, // R4 1.5
    '{2'b00, 1'b0, 64'h3F000000,         64'h1,                 3'b010}, // R4 0.5
    '{2'b00, 1'b0, 64'h3E800000,         64'h0,                 3'b010}, // R4 0.25
    '{2'b00, 1'b0, 64'hBE800000,         64'h0,                 3'b010}, // R7 -0.25
    '{2'b00, 1'b0, 64'hBF000000,         64'h0,                 3'b100}, // R7 -0.5
    '{2'b00, 1'b0, 64'hBF800000,         64'h0,                 3'b100}, // R7 -1.0
    '{2'b00, 1'b0, 64'h80000000,         64'h0,                 3'b000}, // R7 -0
    '{2'b00, 1'b0, 64'h00000000,         64'h0,                 3'b000}, // R7 +0
    '{2'b00, 1'b0, 64'h7FC00000,         64'h0,                 3'b100}, // R5 NaN
    '{2'b00, 1'b0, 64'h7F800000,         64'hFFFFFFFF,          3'b100}, // R6 +inf narrow
    '{2'b00, 1'b1, 64'h7F800000,         64'hFFFFFFFFFFFFFFFF,  3'b100}, // R6 +inf wide
    '{2'b00, 1'b0, 64'h4F800000,         64'hFFFFFFFF,          3'b100}, // R6 2^32 narrow
    '{2'b00, 1'b1, 64'h4F800000,         64'h100000000,         3'b000}, // R3 2^32 wide
    '{2'b00, 1'b0, 64'h4F7FFFFF,         64'hFFFFFF00,          3'b000}, // R3 max single below 2^32
    '{2'b00, 1'b0, 64'h00000001,         64'h0,                 3'b010}, // R8 single subnormal
    '{2'b00, 1'b1, 64'hFF800000,         64'h0,                 3'b100}, // R7 -inf
    '{2'b01, 1'b0, 64'h4004000000000000, 64'h3,                 3'b010}, // R4 double 2.5
    '{2'b01, 1'b1, 64'h43F0000000000000, 64'hFFFFFFFFFFFFFFFF,  3'b100}, // R6 2^64
    '{2'b01, 1'b1, 64'h43EFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFF800,  3'b000}, // R3 below 2^64
    '{2'b01, 1'b0, 64'h41EFFFFFFFF00000, 64'hFFFFFFFF,          3'b100}, // R6 rounds to 2^32
    '{2'b01, 1'b1, 64'h41EFFFFFFFF00000, 64'h100000000,         3'b010}, // R4 rounds to 2^32 wide
    '{2'b01, 1'b0, 64'h3FDFFFFFFFFFFFFF, 64'h0,                 3'b010}, // R4 just below 0.5
    '{2'b01, 1'b0, 64'h0000000000000001, 64'h0,                 3'b010}, // R8 double subnormal
    '{2'b01, 1'b1, 64'h3FF0000000000000, 64'h1,                 3'b000}, // R1 double 1.0
    '{2'b01, 1'b1, 64'h7FF8000000000000, 64'h0,                 3'b100}, // R5 double NaN
    '{2'b11, 1'b0, 64'h3C00,             64'h1,                 3'b000}, // R1 half 1.0
    '{2'b11, 1'b0, 64'h4100,             64'h3,                 3'b010}, // R4 half 2.5
    '{2'b11, 1'b1, 64'h7BFF,             64'hFFE0,              3'b000}, // R1 half max
    '{2'b11, 1'b0, 64'h7C00,             64'hFFFFFFFF,          3'b100}, // R6 half +inf
    '{2'b11, 1'b0, 64'h7E00,             64'h0,                 3'b100}, // R5 half NaN
    '{2'b11, 1'b0, 64'h0001,             64'h0,                 3'b010}, // R8 half subnormal
    '{2'b11, 1'b0, 64'hB800,             64'h0,                 3'b100}, // R7 half -0.5
    '{2'b11, 1'b0, 64'h3800,             64'h1,                 3'b010}, // R4 half 0.5
    '{2'b00, 1'b0, 64'hDEADBEEF3F800000, 64'h1,                 3'b000}, // R1 upper bits ignored
    '{2'b11, 1'b1, 64'hFFFFFFFFFFFF4100, 64'h3,                 3'b010}, // R1 upper bits ignored
    '{2'b10, 1'b1, 64'h3FF0000000000000, 64'h0,                 3'b001}, // R2 illegal code
    '{2'b10, 1'b0, 64'h7FC00000,         64'h0,                 3'b001}, // R2 illegal code NaN
    '{2'b01, 1'b0, 64'h400C000000000000, 64'h4,                 3'b010}, // R4 double 3.5
    '{2'b01, 1'b1, 64'h43E0000000000000, 64'h8000000000000000,  3'b000}  // R3 2^63
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert(input logic [1:0] f, input logic w, input logic [63:0] op);
    @(negedge clk);
    src_fmt  = f;
    dst_wide = w;
    operand  = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 outputs in reset",
          {53'b0, out_valid, exc_invalid, exc_inexact, exc_undef,
           sticky_invalid, sticky_inexact, trap_req, 3'b0}, 64'h0);
    check("R12 result in reset", result, 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      convert(VT[i].f, VT[i].w, VT[i].op);
      n_chk++;
      if (result !== VT[i].res ||
          {exc_invalid, exc_inexact, exc_undef} !== VT[i].fl || out_valid !== 1'b1) begin
        n_bad++;
        $display("FAIL R%0s vec %0d actual=%h/%b/%b expected=%h/%b/1", "1-R12", i,
                 result, {exc_invalid, exc_inexact, exc_undef}, out_valid,
                 VT[i].res, VT[i].fl);
      end
    end

    // R10 valid drops in the idle cycle after a conversion
    @(negedge clk);
    check("R10 out_valid idle", {63'b0, out_valid}, 64'h0);
    // R11 sticky bits set by untrapped exceptions in the table
    check("R11 sticky after table", {62'b0, sticky_invalid, sticky_inexact}, 64'h3);

    // R11 trapped classes: fresh reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R12 sticky cleared", {62'b0, sticky_invalid, sticky_inexact}, 64'h0);

    trap_iv_en = 1'b1;
    convert(2'b00, 1'b0, 64'h7FC00000);
    check("R11 trap on invalid", {61'b0, trap_req, exc_invalid, sticky_invalid}, 64'h6);
    @(negedge clk);
    check("R11 trap pulse ends", {63'b0, trap_req}, 64'h0);

    convert(2'b00, 1'b0, 64'h40200000);
    check("R11 untrapped inexact", {61'b0, trap_req, sticky_inexact, sticky_invalid}, 64'h2);

    trap_ix_en = 1'b1;
    convert(2'b00, 1'b0, 64'h3FC00000);
    check("R11 trap on inexact", {62'b0, trap_req, exc_inexact}, 64'h3);

    convert(2'b00, 1'b0, 64'h3F800000);
    check("R11 exact no trap", {61'b0, trap_req, sticky_inexact, sticky_invalid}, 64'h2);

    trap_iv_en = 1'b0;
    convert(2'b11, 1'b0, 64'hB800);
    check("R11 untrapped invalid", {61'b0, trap_req, sticky_invalid, exc_invalid}, 64'h3);

    // R10 back-to-back conversions
    @(negedge clk);
    src_fmt = 2'b00; dst_wide = 1'b0; operand = 64'h40200000; in_valid = 1'b1;
    @(negedge clk);
    check("R10 first of pair", result, 64'h3);
    operand = 64'h3FC00000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second of pair", {result[62:0], out_valid}, 64'h5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule